// File: doc/BRIEF.md
# Banked Edge-Interrupt Digital I/O Controller

This block serves a group of byte-wide digital I/O ports (three ports of eight lines by default, 24 lines in all) behind a simple byte register bus with an 8-bit offset and separate read and write strobes. Each line has an open-drain style output: a 1 in its output register pulls the pin low, and a 0 releases it. A read of a port returns the pin level after a two-flop synchroniser, so a released pin reads whatever the outside world drives.

Every line can raise an interrupt when its synchronised level goes from 0 to 1 while its enable bit is set. The upper part of the register window is banked. A page register chooses what offsets 8 to 10 show: the per-port enable masks or the per-port pending masks. Software clears a pending line by clearing that line's enable bit and then setting it again. A summary register shows, one bit per port, which ports hold a pending line. A single active-high request output stays high while any line is pending.

Lines are numbered for software from 1 upward. Port p bit b is pin index 8p+b and line 8p+b+1.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset the page is 0, all output, enable and pending bits are 0, `pin_pull_low` is all 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Offset 7 is the page register on every page. A write stores `bus_wdata[7:6]` as the page (00 plain, 10 enable bank, 11 pending bank, 01 unused). A read returns the page in bits 7:6 with bits 5:0 at 0.
- R3: Offsets 0, 1 and 2 are unbanked port registers. A write sets the port's output bits, and bit b at 1 drives `pin_pull_low[8p+b]` high. A read returns the pins after two synchronising flops. Read data appears on `bus_rdata` in the cycle after `bus_rd` and is 0 in any cycle that follows no read.
- R4: With page 10, offsets 8, 9 and 10 write and read back the enable masks of ports 0, 1 and 2.
- R5: A line becomes pending one clock after its synchronised level rises while its enable bit is already 1. Falling edges have no effect, and so do rising edges on disabled lines.
- R6: With page 11, offsets 8, 9 and 10 read the pending masks of ports 0, 1 and 2. Writes there have no effect.
- R7: Offset 6 reads on any page as the port summary: bit p is 1 when any line of port p is pending, and bits 7:3 are 0.
- R8: Writing 0 to a line's enable bit clears its pending bit. Writing 1 again re-arms the line but does not bring the old event back.
- R9: `irq` is high exactly while at least one line is pending. It stays high until the pending lines are cleared through their enables.
- R10: Offsets 3, 4, 5, 11 to 255, and offsets 8 to 10 with page 00 or 01 read as 0. Writes to them change no state.
- R11: Port p bit b maps to `pin_in[8p+b]` and `pin_pull_low[8p+b]`, so line 1 is port 0 bit 0, line 9 is port 1 bit 0 and line 24 is port 2 bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data follows one cycle later |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, 0 when no read is returning |
| pin_in | input | 24 | Asynchronous pin levels |
| pin_pull_low | output | 24 | 1 pulls the pin low, 0 releases it |
| irq | output | 1 | High while any line is pending |

## Verification
The bench builds the block with its default three ports of eight lines. At this size the whole 16-byte window is live: offset 10 and line 24 exist, the summary register has all three bits in use, and every undefined offset between the banks can be probed. A behavioural model of all 24 lines follows the pins through the synchroniser. Under random page changes, enable writes and pin toggling, it can therefore catch an edge that arrives in the same cycle as an enable write.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;

    // Selector of what the banked offsets show
    typedef enum logic [1:0] {
        PG_IO     = 2'b00,
        PG_SPARE  = 2'b01,
        PG_ENABLE = 2'b10,
        PG_IDENT  = 2'b11
    } page_e;

    localparam logic [7:0] OFS_MASTER = 8'd6;
    localparam logic [7:0] OFS_PAGE   = 8'd7;
    localparam logic [7:0] OFS_BANK   = 8'd8;
    localparam logic [7:0] WIN_SIZE   = 8'd16;

endpackage

// File: rtl/dio_sync_edge.sv
module dio_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] hist;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw;
        st_d.sync = st_q.meta;
        st_d.hist = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sync;
    assign rise  = st_q.sync & ~st_q.hist;

endmodule

// File: rtl/dio_port_bank.sv
module dio_port_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rise,
    output logic [W-1:0] out_bits,
    output logic [W-1:0] en_bits,
    output logic [W-1:0] pend_bits
);

    typedef struct packed {
        logic [W-1:0] drv;
        logic [W-1:0] en;
        logic [W-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (out_we) begin
            st_d.drv = wdata;
        end
        if (en_we) begin
            st_d.en = wdata;
        end
        // an edge only counts against the enable already in force;
        // dropping an enable wipes the line's pending flag
        st_d.pend = (st_q.pend | (rise & st_q.en)) & st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bits  = st_q.drv;
    assign en_bits   = st_q.en;
    assign pend_bits = st_q.pend;

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
    import dio_irq_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int PORT_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic [N_PORTS*PORT_W-1:0]   pin_in,
    output logic [N_PORTS*PORT_W-1:0]   pin_pull_low,
    output logic                        irq
);

    localparam int NL = N_PORTS * PORT_W;

    typedef struct packed {
        page_e      page;
        logic [7:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [N_PORTS-1:0][PORT_W-1:0] lvl;
    logic [N_PORTS-1:0][PORT_W-1:0] rise;
    logic [N_PORTS-1:0][PORT_W-1:0] drv;
    logic [N_PORTS-1:0][PORT_W-1:0] en;
    logic [N_PORTS-1:0][PORT_W-1:0] pend;
    logic [N_PORTS-1:0]             out_we;
    logic [N_PORTS-1:0]             en_we;
    logic [N_PORTS-1:0]             port_hit;
    logic [NL-1:0]                  en_all;
    logic [NL-1:0]                  pend_all;

    dio_sync_edge #(.W(NL)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .level (lvl),
        .rise  (rise)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign out_we[p] = bus_wr && (bus_addr == 8'(p));
        assign en_we[p]  = bus_wr && (st_q.page == PG_ENABLE)
                           && (bus_addr == OFS_BANK + 8'(p));

        dio_port_bank #(.W(PORT_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .out_we    (out_we[p]),
            .en_we     (en_we[p]),
            .wdata     (bus_wdata[PORT_W-1:0]),
            .rise      (rise[p]),
            .out_bits  (drv[p]),
            .en_bits   (en[p]),
            .pend_bits (pend[p])
        );

        assign port_hit[p] = |pend[p];
    end

    assign en_all       = en;
    assign pend_all     = pend;
    assign pin_pull_low = drv;

    always_comb begin
        logic [7:0] rd_val;
        st_d   = st_q;
        rd_val = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (bus_addr == 8'(p)) begin
                rd_val[PORT_W-1:0] = lvl[p];
            end
            if (bus_addr == OFS_BANK + 8'(p)) begin
                if (st_q.page == PG_ENABLE) begin
                    rd_val[PORT_W-1:0] = en[p];
                end else if (st_q.page == PG_IDENT) begin
                    rd_val[PORT_W-1:0] = pend[p];
                end
            end
        end
        if (bus_addr == OFS_MASTER) begin
            rd_val[N_PORTS-1:0] = port_hit;
        end
        if (bus_addr == OFS_PAGE) begin
            rd_val = {st_q.page, 6'b0};
        end
        st_d.rdata = bus_rd ? rd_val : 8'h00;
        if (bus_wr && (bus_addr == OFS_PAGE)) begin
            st_d.page = page_e'(bus_wdata[7:6]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{page: PG_IO, rdata: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |port_hit;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NL = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic [NL-1:0] pin_pull_low,
    input logic          irq,
    input logic [NL-1:0] en_all,
    input logic [NL-1:0] pend_all
);

    p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 8'h00));

    p_master_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'd6) |=> (bus_rdata[7:3] == 5'b0));

    p_pend_on_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_all & ~en_all) == '0));

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|en_all));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    p_undef_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= 8'd16) |=> ($stable(pin_pull_low) && $stable(en_all)));

endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(.NL(N_PORTS * PORT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .pin_pull_low (pin_pull_low),
    .irq          (irq),
    .en_all       (en_all),
    .pend_all     (pend_all)
);

// File: tb/gpio_edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_pull_low;
    logic        irq;

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gpio_edge_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .pin_pull_low (pin_pull_low),
        .irq          (irq)
    );

    // behavioural reference of the register file and the 24 lines
    logic [23:0] m_s1, m_s2, m_s3, m_out, m_en, m_pend;
    logic [1:0]  m_page;
    logic [7:0]  m_rd;

    always @(posedge clk or negedge rst_n) begin
        int a;
        logic [7:0]  v;
        logic [23:0] new_en;
        logic [23:0] edges;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            m_out = '0; m_en = '0; m_pend = '0;
            m_page = 2'b00; m_rd = '0;
        end else begin
            a = int'(bus_addr);
            v = 8'h00;
            if (a < 3) v = m_s2[8*a +: 8];
            else if (a == 6) v = {5'b0, |m_pend[23:16], |m_pend[15:8], |m_pend[7:0]};
            else if (a == 7) v = {m_page, 6'b0};
            else if (a >= 8 && a <= 10) begin
                if (m_page == 2'b10) v = m_en[8*(a-8) +: 8];
                else if (m_page == 2'b11) v = m_pend[8*(a-8) +: 8];
            end
            m_rd = bus_rd ? v : 8'h00;
            new_en = m_en;
            if (bus_wr && a >= 8 && a <= 10 && m_page == 2'b10)
                new_en[8*(a-8) +: 8] = bus_wdata;
            edges  = m_s2 & ~m_s3;
            m_pend = (m_pend | (edges & m_en)) & new_en;
            m_en   = new_en;
            if (bus_wr && a < 3) m_out[8*a +: 8] = bus_wdata;
            if (bus_wr && a == 7) m_page = bus_wdata[7:6];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            check(cur_req, 32'(bus_rdata), 32'(m_rd));
            check("R3", 32'(pin_pull_low), 32'(m_out));
            check("R9", 32'(irq), 32'(|m_pend));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(5ns * 100000);
        if (!done) begin
            done = 1'b1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1", 32'(irq), 0);
        check("R1", 32'(pin_pull_low), 0);
        check("R1", 32'(bus_rdata), 0);
        rd(8'd7, 8'h00, "R1");

        // R3 / R11 outputs and synchronised reads
        cur_req = "R3";
        wr(8'd0, 8'hA5);
        check("R3", 32'(pin_pull_low), 32'h0000A5);
        wr(8'd2, 8'h3C);
        check("R11", 32'(pin_pull_low), 32'h3C00A5);
        wr(8'd0, 8'h00);
        wr(8'd2, 8'h00);
        check("R3", 32'(pin_pull_low), 32'h0);
        pin_in = 24'h123456;
        idle(3);
        rd(8'd0, 8'h56, "R11");
        rd(8'd1, 8'h34, "R3");
        rd(8'd2, 8'h12, "R11");
        pin_in = 24'h0;
        idle(3);

        // R2 / R4 page and enables
        cur_req = "R2";
        wr(8'd7, 8'h80);
        rd(8'd7, 8'h80, "R2");
        cur_req = "R4";
        wr(8'd8, 8'h01);
        wr(8'd9, 8'h80);
        wr(8'd10, 8'h80);
        rd(8'd9, 8'h80, "R4");
        rd(8'd8, 8'h01, "R4");

        // R5 edges
        cur_req = "R5";
        pin_in[0] = 1'b1;
        idle(4);
        check("R5", 32'(irq), 1);
        wr(8'd7, 8'hC0);
        rd(8'd8, 8'h01, "R6");
        rd(8'd6, 8'h01, "R7");
        pin_in[0] = 1'b0;
        pin_in[8] = 1'b1;
        idle(4);
        rd(8'd9, 8'h00, "R5");
        pin_in[15] = 1'b1;
        idle(4);
        rd(8'd9, 8'h80, "R5");
        rd(8'd6, 8'h03, "R7");
        cur_req = "R6";
        wr(8'd8, 8'h00);
        rd(8'd8, 8'h01, "R6");

        // R8 clear by disabling, re-arm
        cur_req = "R8";
        wr(8'd7, 8'h80);
        wr(8'd8, 8'h00);
        wr(8'd8, 8'h01);
        check("R9", 32'(irq), 1);
        wr(8'd7, 8'hC0);
        rd(8'd8, 8'h00, "R8");
        wr(8'd7, 8'h80);
        wr(8'd9, 8'h00);
        check("R8", 32'(irq), 0);
        rd(8'd6, 8'h00, "R7");

        // R10 undefined offsets
        cur_req = "R10";
        wr(8'd3, 8'hFF);
        wr(8'd20, 8'hFF);
        check("R10", 32'(pin_pull_low), 0);
        rd(8'd3, 8'h00, "R10");
        rd(8'd5, 8'h00, "R10");
        rd(8'd12, 8'h00, "R10");
        rd(8'd200, 8'h00, "R10");
        wr(8'd7, 8'h40);
        rd(8'd7, 8'h40, "R2");
        rd(8'd8, 8'h00, "R10");
        wr(8'd7, 8'h00);
        rd(8'd9, 8'h00, "R10");

        // R11 line 24
        cur_req = "R11";
        pin_in[23] = 1'b1;
        idle(4);
        wr(8'd7, 8'hC0);
        rd(8'd10, 8'h80, "R11");
        rd(8'd6, 8'h04, "R11");
        check("R9", 32'(irq), 1);

        // random traffic against the model
        cur_req = "R5";
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'h0) pin_in = pin_in ^ {lfsr[23:8], lfsr[31:24]};
            bus_wr    = (lfsr[6:4] == 3'd0);
            bus_rd    = lfsr[7];
            bus_addr  = {4'h0, lfsr[11:8]};
            bus_wdata = lfsr[19:12];
            if (bus_wr && bus_addr == 8'd7) bus_wdata[7] = 1'b1;
            @(negedge clk);
        end
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule